// File: doc/BRIEF.md
# Triggered Pulse Output Port

This block drives eight output pins from patterns that software loads ahead of time. Software writes a mode register and two staging registers through a simple write port. The staged values reach the output latches only when a chosen hardware strobe arrives, so the pins move in step with a timer event and not with the timing of the software write. The pins can change on an exact timer boundary even when the processor is busy.

The low six latches load together on one trigger. Software picks this trigger from a timer strobe, an external strobe, either of the two, or none. The middle pair of those six comes from one of the two staging registers, and a mode bit chooses which one. The top pair loads on a separate strobe from a second timer. The three lowest pins can each be ANDed with a PWM level. One register bit inverts all eight pins. An output-cut input clears the latches at once, without waiting for a clock, for each group whose arm bit is set. The timers sit outside the block. Their events and PWM waveforms arrive as strobes and levels.

Top module: `trig_pulse_port`

## Requirements
- R1: The port is active only when mode[2:0] = 3'b001. With any other value the pins read 8'h00 and trigger strobes load no latch.
- R2: On a low-group trigger, staging register 0 bits [3:0] load latches 0..3. Pins 0..3 show the new value from the clock edge that samples the strobe, and they hold it until the next low-group trigger.
- R3: Staging register 0 bits [7:6] select the low-group trigger: 00 is strobe tmr0_evt, 01 is ext_evt, 10 is either strobe, and 11 is none. A strobe that is not selected has no effect.
- R4: On a low-group trigger, latches 4..5 load from staging register 0 bits [5:4] when mode[3] = 0, and from staging register 1 bits [5:4] when mode[3] = 1.
- R5: Latches 6..7 load from staging register 1 bits [7:6] only on the tmr3_evt strobe. The low-group trigger does not touch them.
- R6: When staging register 1 bit k (k = 0..2) is set, pin k is latch k ANDed with its selected PWM level. When the bit is clear, pin k is latch k.
- R7: Mode bits [5:4] choose the PWM levels. 00 gives pin k the level pwm_lvl[k]. 01, 10 and 11 give all three gated pins pwm_lvl[0], pwm_lvl[1] and pwm_lvl[2] respectively.
- R8: When staging register 1 bit 3 is set, all eight active pins are inverted. The inversion is applied after the PWM gating.
- R9: While cut_in is high, mode bit 7 clears latches 0..5 and mode bit 6 clears latches 6..7 at once, without a clock edge. Triggers cannot load a cleared group until cut_in falls.
- R10: When a register write and a trigger happen in the same cycle, the latches take the newly written value.
- R11: After reset, all registers and latches are zero and the pins read 8'h00. Register addresses are 0 for mode, 1 for staging register 0 and 2 for staging register 1. A write to address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 staging 0, 2 staging 1 |
| wr_data | input | 8 | Register write data |
| tmr0_evt | input | 1 | One-cycle strobe from the primary timer |
| ext_evt | input | 1 | One-cycle external trigger strobe |
| tmr3_evt | input | 1 | One-cycle strobe that loads the top pair |
| pwm_lvl | input | 3 | PWM levels from three external timers |
| cut_in | input | 1 | Output-cut request, active high, acts without a clock edge |
| pins_out | output | 8 | Pulse output pins |

## Verification
Each latch drives its own pin directly, so a wrong latch state appears on the pins as soon as the edge that made the error has passed. A trigger that is missed, or that is accepted when it should not be, leaves a stale or early pattern on the pins until the next legal trigger. The bench therefore samples the pins one half-cycle after every strobe. It also samples them before any strobe that a test expects to be ignored. A PWM level or polarity bit routed to the wrong place shows up as soon as the PWM levels are changed. A cut path that is slow or wrongly armed shows on the pins before the next clock edge.

// File: rtl/tpp_pkg.sv
`timescale 1ns/1ps
package tpp_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned LO_N   = 4;
  localparam int unsigned MID_N  = 2;
  localparam int unsigned HI_N   = 2;
  localparam int unsigned PWM_N  = 3;
  localparam int unsigned GRP_A  = LO_N + MID_N;
  localparam int unsigned PINS_N = GRP_A + HI_N;
  localparam logic [2:0]  SEL_PULSE = 3'b001;

  typedef struct packed {
    logic       arm_a;     // bit 7: cut clears latches 0..5
    logic       arm_b;     // bit 6: cut clears latches 6..7
    logic [1:0] pwm_sel;   // bits 5:4
    logic       mid_src;   // bit 3
    logic [2:0] wsel;      // bits 2:0
  } mode_t;

  typedef struct packed {
    logic [1:0]      trg_sel;
    logic [MID_N-1:0] mid_a;
    logic [LO_N-1:0]  low;
  } stage0_t;

  typedef struct packed {
    logic [HI_N-1:0]  high;
    logic [MID_N-1:0] mid_b;
    logic             pol;
    logic [PWM_N-1:0] pwm_en;
  } stage1_t;

  function automatic logic trig_hit(input logic [1:0] sel, input logic t0, input logic tx);
    case (sel)
      2'b00:   return t0;
      2'b01:   return tx;
      2'b10:   return t0 | tx;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic pwm_pick(input logic [1:0] sel, input int unsigned idx,
                                    input logic [PWM_N-1:0] lvl);
    if (sel == 2'b00) return lvl[idx];
    return lvl[sel - 2'd1];
  endfunction

  function automatic logic shape_bit(input logic lat, input logic en,
                                     input logic pwm, input logic pol);
    return pol ^ (lat & (~en | pwm));
  endfunction
endpackage

// File: rtl/tpp_regs.sv
`timescale 1ns/1ps
module tpp_regs
  import tpp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output mode_t            mode_q,
  output stage0_t          st0_q,
  output stage1_t          st1_q,
  output mode_t            mode_n,
  output stage0_t          st0_n,
  output stage1_t          st1_n
);
  logic hit_mode, hit_st0, hit_st1;

  assign hit_mode = wr_en && (wr_addr == 2'd0);
  assign hit_st0  = wr_en && (wr_addr == 2'd1);
  assign hit_st1  = wr_en && (wr_addr == 2'd2);

  assign mode_n = hit_mode ? mode_t'(wr_data)   : mode_q;
  assign st0_n  = hit_st0  ? stage0_t'(wr_data) : st0_q;
  assign st1_n  = hit_st1  ? stage1_t'(wr_data) : st1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      st0_q  <= '0;
      st1_q  <= '0;
    end else begin
      mode_q <= mode_n;
      st0_q  <= st0_n;
      st1_q  <= st1_n;
    end
  end

  // R11: a write to the unused address leaves every register unchanged
  p_spare_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> ($stable(mode_q) && $stable(st0_q) && $stable(st1_q)));
endmodule

// File: rtl/tpp_latch.sv
`timescale 1ns/1ps
module tpp_latch
  import tpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cut_in,
  input  mode_t             mode_q,
  input  mode_t             mode_n,
  input  stage0_t           st0_n,
  input  stage1_t           st1_n,
  input  logic              tmr0_evt,
  input  logic              ext_evt,
  input  logic              tmr3_evt,
  output logic [PINS_N-1:0] lat
);
  logic              port_on;
  logic              fire_a, fire_b;
  logic              clr_a, clr_b;
  logic [MID_N-1:0]  mid_next;
  logic [GRP_A-1:0]  lat_a;
  logic [HI_N-1:0]   lat_b;

  assign port_on  = (mode_n.wsel == SEL_PULSE);
  assign fire_a   = port_on && trig_hit(st0_n.trg_sel, tmr0_evt, ext_evt);
  assign fire_b   = port_on && tmr3_evt;
  assign mid_next = mode_n.mid_src ? st1_n.mid_b : st0_n.mid_a;
  assign clr_a    = !rst_n || (cut_in && mode_q.arm_a);
  assign clr_b    = !rst_n || (cut_in && mode_q.arm_b);

  always_ff @(posedge clk or posedge clr_a) begin
    if (clr_a)       lat_a <= '0;
    else if (fire_a) lat_a <= {mid_next, st0_n.low};
  end

  always_ff @(posedge clk or posedge clr_b) begin
    if (clr_b)       lat_b <= '0;
    else if (fire_b) lat_b <= st1_n.high;
  end

  assign lat = {lat_b, lat_a};

  p_low_load_r2: assert property (@(posedge clk) disable iff (!rst_n || cut_in)
    fire_a |=> lat[LO_N-1:0] == $past(st0_n.low));
  p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n || cut_in)
    !fire_a |=> $stable(lat[GRP_A-1:0]));
  p_mid_src_r4: assert property (@(posedge clk) disable iff (!rst_n || cut_in)
    (fire_a && mode_n.mid_src) |=> lat[GRP_A-1:LO_N] == $past(st1_n.mid_b));
  p_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n || cut_in)
    !tmr3_evt |=> $stable(lat[PINS_N-1:GRP_A]));
  p_cut_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_in && mode_q.arm_a) |-> lat[GRP_A-1:0] == '0);
  p_cut_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_in && mode_q.arm_b) |-> lat[PINS_N-1:GRP_A] == '0);
  p_off_noload_r1: assert property (@(posedge clk) disable iff (!rst_n || cut_in)
    (mode_n.wsel != SEL_PULSE) |=> $stable(lat));
endmodule

// File: rtl/tpp_shape.sv
`timescale 1ns/1ps
module tpp_shape
  import tpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS_N-1:0] lat,
  input  mode_t             mode_q,
  input  stage1_t           st1_q,
  input  logic [PWM_N-1:0]  pwm_lvl,
  output logic [PINS_N-1:0] pins
);
  logic              active;
  logic [PINS_N-1:0] shaped;
  logic [PWM_N-1:0]  gate_lvl;

  assign active = (mode_q.wsel == SEL_PULSE);

  for (genvar k = 0; k < PINS_N; k++) begin : g_pin
    if (k < PWM_N) begin : g_gated
      assign gate_lvl[k] = pwm_pick(mode_q.pwm_sel, k, pwm_lvl);
      assign shaped[k]   = shape_bit(lat[k], st1_q.pwm_en[k], gate_lvl[k], st1_q.pol);
    end else begin : g_plain
      assign shaped[k]   = shape_bit(lat[k], 1'b0, 1'b1, st1_q.pol);
    end
  end

  assign pins = active ? shaped : '0;

  // R6: an enabled gate with its PWM level low forces the pin to the polarity level
  p_gate_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st1_q.pwm_en[0] && !gate_lvl[0]) |-> pins[0] == st1_q.pol);
  // R8: ungated pins follow latch XOR polarity
  p_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> pins[PINS_N-1:PWM_N] == (lat[PINS_N-1:PWM_N] ^ {(PINS_N-PWM_N){st1_q.pol}}));
endmodule

// File: rtl/trig_pulse_port.sv
`timescale 1ns/1ps
module trig_pulse_port
  import tpp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  tmr0_evt,
  input  logic                  ext_evt,
  input  logic                  tmr3_evt,
  input  logic [PWM_N-1:0]      pwm_lvl,
  input  logic                  cut_in,
  output logic [PINS_N-1:0]     pins_out
);
  mode_t             mode_q, mode_n;
  stage0_t           st0_q, st0_n;
  stage1_t           st1_q, st1_n;
  logic [PINS_N-1:0] lat;

  tpp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .st0_q(st0_q), .st1_q(st1_q),
    .mode_n(mode_n), .st0_n(st0_n), .st1_n(st1_n)
  );

  tpp_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cut_in(cut_in),
    .mode_q(mode_q), .mode_n(mode_n), .st0_n(st0_n), .st1_n(st1_n),
    .tmr0_evt(tmr0_evt), .ext_evt(ext_evt), .tmr3_evt(tmr3_evt),
    .lat(lat)
  );

  tpp_shape u_shape (
    .clk(clk), .rst_n(rst_n), .lat(lat), .mode_q(mode_q), .st1_q(st1_q),
    .pwm_lvl(pwm_lvl), .pins(pins_out)
  );

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.wsel != SEL_PULSE) |-> pins_out == '0);
endmodule

// File: tb/trig_pulse_port_tb.sv
`timescale 1ns/1ps
module trig_pulse_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tmr0_evt = 1'b0, ext_evt = 1'b0, tmr3_evt = 1'b0;
  logic [2:0] pwm_lvl = '0;
  logic       cut_in = 1'b0;
  logic [7:0] pins_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_pulse_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr0_evt(tmr0_evt), .ext_evt(ext_evt), .tmr3_evt(tmr3_evt),
    .pwm_lvl(pwm_lvl), .cut_in(cut_in), .pins_out(pins_out)
  );

  task automatic chk(input string tag, input logic [7:0] exp);
    n_chk++;
    if (pins_out !== exp) begin
      n_fail++;
      $display("FAIL %s: pins actual=%02h expected=%02h", tag, pins_out, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 0; tmr0_evt = 0; ext_evt = 0; tmr3_evt = 0; pwm_lvl = '0; cut_in = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // which: 0 = tmr0, 1 = ext, 2 = tmr3
  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) tmr0_evt = 1;
    if (which == 1) ext_evt = 1;
    if (which == 2) tmr3_evt = 1;
    @(negedge clk);
    tmr0_evt = 0; ext_evt = 0; tmr3_evt = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 reset pins", 8'h00);
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h01);
    pulse(0);
    chk("R11 spare address write ignored", 8'h00);
  endtask

  task automatic t_off();
    do_reset();
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h08);
    pulse(0);
    chk("R1 off mode pins quiet", 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    chk("R1 trigger while off loaded nothing", 8'h00);
    wr(2'd0, 8'h02);
    pulse(0);
    chk("R1 other function value stays quiet", 8'h00);
  endtask

  task automatic t_low();
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h05);
    pulse(1);
    chk("R3 ext ignored when tmr0 selected", 8'h00);
    pulse(0);
    chk("R2 low load on tmr0", 8'h05);
    wr(2'd1, 8'h4A);
    chk("R2 hold before trigger", 8'h05);
    pulse(0);
    chk("R3 tmr0 ignored when ext selected", 8'h05);
    pulse(1);
    chk("R3 ext load", 8'h0A);
    wr(2'd1, 8'h83);
    pulse(1);
    chk("R3 either selected, ext", 8'h03);
    wr(2'd1, 8'h8C);
    pulse(0);
    chk("R3 either selected, tmr0", 8'h0C);
    wr(2'd1, 8'hC1);
    pulse(0);
    pulse(1);
    chk("R3 none selected", 8'h0C);
  endtask

  task automatic t_mid();
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h20);
    wr(2'd1, 8'h10);
    pulse(0);
    chk("R4 middle from staging 0", 8'h10);
    wr(2'd0, 8'h09);
    pulse(0);
    chk("R4 middle from staging 1", 8'h20);
  endtask

  task automatic t_high();
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hC0);
    pulse(0);
    chk("R5 top pair not loaded by low trigger", 8'h00);
    pulse(2);
    chk("R5 top pair on tmr3", 8'hC0);
    wr(2'd2, 8'h40);
    chk("R5 hold before tmr3", 8'hC0);
    pulse(2);
    chk("R5 reload on tmr3", 8'h40);
  endtask

  task automatic t_pwm();
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h07);
    wr(2'd2, 8'h07);
    pulse(0);
    pwm_lvl = 3'b000; #1 chk("R6 all gated low", 8'h00);
    pwm_lvl = 3'b101; #1 chk("R6 per-bit gating", 8'h05);
    pwm_lvl = 3'b111; #1 chk("R6 all gated high", 8'h07);
    wr(2'd2, 8'h05);
    pwm_lvl = 3'b000; #1 chk("R6 ungated bit passes", 8'h02);
    wr(2'd2, 8'h07);
    wr(2'd0, 8'h11);
    pwm_lvl = 3'b001; #1 chk("R7 all from level 0", 8'h07);
    pwm_lvl = 3'b110; #1 chk("R7 level 0 low", 8'h00);
    wr(2'd0, 8'h21);
    pwm_lvl = 3'b010; #1 chk("R7 all from level 1", 8'h07);
    wr(2'd0, 8'h31);
    pwm_lvl = 3'b100; #1 chk("R7 all from level 2", 8'h07);
    pwm_lvl = 3'b011; #1 chk("R7 level 2 low", 8'h00);
    pwm_lvl = 3'b000;
  endtask

  task automatic t_pol();
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h08);
    chk("R8 inverted idle", 8'hFF);
    wr(2'd1, 8'h03);
    pulse(0);
    chk("R8 inverted pattern", 8'hFC);
    wr(2'd2, 8'h09);
    pwm_lvl = 3'b000; #1 chk("R8 inversion after gating", 8'hFD);
    wr(2'd0, 8'h00);
    chk("R1 off overrides polarity", 8'h00);
  endtask

  task automatic t_cut();
    do_reset();
    wr(2'd0, 8'hC1);
    wr(2'd1, 8'h3F);
    wr(2'd2, 8'hC0);
    pulse(0);
    pulse(2);
    chk("R9 loaded before cut", 8'hFF);
    @(negedge clk);
    cut_in = 1; #1
    chk("R9 cut clears without edge", 8'h00);
    pulse(0);
    chk("R9 trigger blocked while cut", 8'h00);
    cut_in = 0;
    pulse(0);
    chk("R9 low group reload after cut", 8'h3F);
    wr(2'd0, 8'h41);
    pulse(2);
    @(negedge clk);
    cut_in = 1; #1
    chk("R9 only top pair armed", 8'h3F);
    @(negedge clk);
    cut_in = 0;
    wr(2'd0, 8'h81);
    @(negedge clk);
    cut_in = 1; #1
    chk("R9 only low group armed", 8'h00);
    @(negedge clk);
    cut_in = 0;
  endtask

  task automatic t_same();
    do_reset();
    wr(2'd0, 8'h01);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd1; wr_data = 8'h09; tmr0_evt = 1;
    @(negedge clk);
    wr_en = 0; tmr0_evt = 0;
    chk("R10 same-cycle write and trigger", 8'h09);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd1; wr_data = 8'h46; ext_evt = 1;
    @(negedge clk);
    wr_en = 0; ext_evt = 0;
    chk("R10 same-cycle trigger select change", 8'h06);
  endtask

  initial begin
    t_reset();
    t_off();
    t_low();
    t_mid();
    t_high();
    t_pwm();
    t_pol();
    t_cut();
    t_same();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule